// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter, four bits wide by default, in which every bit is updated on the same rising clock edge. On each edge it does one of four things. It can take a parallel value from its data inputs. It can step up by one or down by one, with the count wrapping at both ends. Otherwise it holds its value. Two active-low enables gate counting, and a direction input picks the way the count moves.

A combinational, active-low carry flags the terminal count for the current direction: all ones when counting up, all zeros when counting down. Only the second enable qualifies this carry. Wider counters are built by chaining stages. Each stage's carry drives the carry-gating enable of the next stage, and all stages share the clock, the first enable and the direction. A chain built this way steps as one wide synchronous counter with no glue logic. No reset exists, so the count is defined only after the first load.

Top module: `ctr_updown`

## Requirements
- R1: When `load_n` is low at a rising edge, `q` takes `din` at that edge, whatever the levels of `en_p_n`, `en_t_n` and `up`.
- R2: When `load_n` is high, both `en_p_n` and `en_t_n` are low and `up` is 1, `q` becomes `(q+1) mod 2^WIDTH` at the edge, so 15 wraps to 0.
- R3: When `load_n` is high, both enables are low and `up` is 0, `q` becomes `(q-1) mod 2^WIDTH` at the edge, so 0 wraps to 15.
- R4: When `load_n` is high and either `en_p_n` or `en_t_n` is high, `q` keeps its value across the edge.
- R5: `carry_n` is 0 exactly when `en_t_n` is 0 and either `up` is 1 with `q` all ones, or `up` is 0 with `q` all zeros. It follows its inputs combinationally, with no clock needed.
- R6: `carry_n` is 1 whenever `en_t_n` is 1, regardless of `q` and `up`.
- R7: Two stages form an 8-bit counter whose value is `{high.q, low.q}` when they are wired as follows: the low stage's `carry_n` drives the high stage's `en_t_n`, the low stage's `en_t_n` is tied to 0, and `clk`, `en_p_n`, `up` and `load_n` are shared. This counter steps correctly across the 4-bit boundary in both directions and wraps modulo 256.
- R8: Changes on `load_n`, `en_p_n`, `en_t_n`, `up` or `din` between rising edges leave `q` unchanged. Only the levels sampled at an edge decide the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all count bits |
| load_n | input | 1 | Active-low synchronous parallel load, highest priority |
| en_p_n | input | 1 | Active-low count enable, no effect on the carry |
| en_t_n | input | 1 | Active-low count enable that also qualifies the carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count carry for cascading |

## Verification
The bench walks every start value through load, both count directions and both hold cases. It catches a counter that wraps wrongly at 15 or 0, a counter that steps while only one enable is low, or a load that loses to the enables. It sweeps the carry over every count, direction and carry-gating level. A decode that used the wrong terminal value for a direction, or that let the first enable gate it, would show up on the port. A chained 8-bit pair is driven up and then down through several full wraps. A high nibble that stepped one edge early or late at the 0x0F/0x10 boundary, or failed to borrow at 0x00, would break the sequence. Mid-cycle input wiggles check that nothing changes between edges.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] cur,
  output ctr_op_e          op,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // load wins; counting needs both enables low
  always_comb begin
    if (!load_n)                 op = OP_LOAD;
    else if (en_p_n || en_t_n)   op = OP_HOLD;
    else if (up)                 op = OP_INC;
    else                         op = OP_DEC;
  end

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_INC:  nxt = cur + ONE;
      OP_DEC:  nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_tc.sv
module ctr_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             up,
  input  logic             en_t_n,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  logic at_end;
  assign at_end  = up ? (cur == TOP) : (cur == BOT);
  assign carry_n = ~(at_end & ~en_t_n);
endmodule

// File: rtl/ctr_updown.sv
module ctr_updown
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

  ctr_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] cnt_q;

  ctr_next #(.WIDTH(WIDTH)) u_next (
    .load_n(load_n), .en_p_n(en_p_n), .en_t_n(en_t_n), .up(up),
    .din(din), .cur(cnt_q), .op(op), .nxt(nxt)
  );

  always_ff @(posedge clk) cnt_q <= nxt;

  ctr_tc #(.WIDTH(WIDTH)) u_tc (
    .cur(cnt_q), .up(up), .en_t_n(en_t_n), .carry_n(carry_n)
  );

  assign q = cnt_q;

  // checker qualifier: true once a first edge has passed
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  a_r1_load: assert property (@(posedge clk) disable iff (!primed)
    !load_n |=> q == $past(din));
  a_r2_up: assert property (@(posedge clk) disable iff (!primed)
    (load_n && !en_p_n && !en_t_n && up) |=> q == WIDTH'($past(q) + 1'b1));
  a_r3_down: assert property (@(posedge clk) disable iff (!primed)
    (load_n && !en_p_n && !en_t_n && !up) |=> q == WIDTH'($past(q) - 1'b1));
  a_r4_hold: assert property (@(posedge clk) disable iff (!primed)
    (load_n && (en_p_n || en_t_n)) |=> $stable(q));
  a_r5_carry_up: assert property (@(posedge clk) disable iff (!primed)
    (!en_t_n && up && q == ALL1) |-> !carry_n);
  a_r5_carry_dn: assert property (@(posedge clk) disable iff (!primed)
    (!en_t_n && !up && q == '0) |-> !carry_n);
  a_r6_carry_t: assert property (@(posedge clk) disable iff (!primed)
    !carry_n |-> !en_t_n);
endmodule

// File: tb/ctr_updown_tb.sv
module ctr_updown_tb;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic load_n = 1'b1, en_p_n = 1'b1, en_t_n = 1'b1, up = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic carry_n;

  // second chain stage for the cascade test
  logic [W-1:0] q_hi;
  logic carry_hi_n;

  int checks = 0;
  int errors = 0;

  ctr_updown #(.WIDTH(W)) u_dut (
    .clk(clk), .load_n(load_n), .en_p_n(en_p_n), .en_t_n(en_t_n),
    .up(up), .din(din), .q(q), .carry_n(carry_n)
  );

  logic [W-1:0] din_hi = '0;
  ctr_updown #(.WIDTH(W)) u_hi (
    .clk(clk), .load_n(load_n), .en_p_n(en_p_n), .en_t_n(carry_n),
    .up(up), .din(din_hi), .q(q_hi), .carry_n(carry_hi_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic preset(input int v);
    load_n = 1'b0; din = W'(v);
    tick();
    load_n = 1'b1;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // initial state through the load path
    en_t_n = 1'b0; en_p_n = 1'b0;
    preset(0);
    chk("R1 init", int'(q), 0);

    for (int s = 0; s < M; s++) begin
      // R1: load beats active enables, any direction
      for (int d = 0; d < 2; d++) begin
        preset(s);
        en_p_n = 1'b0; en_t_n = 1'b0; up = d[0];
        load_n = 1'b0; din = W'((s * 7 + 3) % M);
        tick();
        load_n = 1'b1;
        chk("R1 load", int'(q), (s * 7 + 3) % M);
      end
      // R2 up
      preset(s); en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1;
      tick();
      chk("R2 up", int'(q), (s + 1) % M);
      // R3 down
      preset(s); up = 1'b0;
      tick();
      chk("R3 down", int'(q), (s + M - 1) % M);
      // R4 hold with each enable high
      preset(s); en_p_n = 1'b1; en_t_n = 1'b0; up = 1'b1;
      tick();
      chk("R4 hold p", int'(q), s);
      preset(s); en_p_n = 1'b0; en_t_n = 1'b1; up = 1'b0;
      tick();
      chk("R4 hold t", int'(q), s);
      // R5/R6 carry sweep, combinational
      en_p_n = 1'b1;
      for (int c = 0; c < 4; c++) begin
        en_t_n = c[0]; up = c[1];
        #1;
        if (en_t_n)
          chk("R6 carry gated", int'(carry_n), 1);
        else
          chk("R5 carry", int'(carry_n),
              ((up && s == M - 1) || (!up && s == 0)) ? 0 : 1);
      end
      // R8: mid-cycle wiggles do not move q
      load_n = 1'b0; din = W'(~s); en_p_n = 1'b0; en_t_n = 1'b0;
      #2;
      load_n = 1'b1; up = ~up;
      #2;
      chk("R8 no change between edges", int'(q), s);
      en_p_n = 1'b1;
    end

    // R7: cascade up then down across several wraps
    en_p_n = 1'b0; en_t_n = 1'b0;
    load_n = 1'b0; din = 4'hA; din_hi = 4'hF;
    tick();
    load_n = 1'b1;
    begin
      int exp = 8'hFA;
      up = 1'b1;
      for (int i = 0; i < 600; i++) begin
        tick();
        exp = (exp + 1) % 256;
        chk("R7 cascade up", int'({q_hi, q}), exp);
      end
      up = 1'b0;
      for (int i = 0; i < 600; i++) begin
        tick();
        exp = (exp + 255) % 256;
        chk("R7 cascade down", int'({q_hi, q}), exp);
      end
      en_p_n = 1'b1;
      tick();
      chk("R7 cascade hold", int'({q_hi, q}), exp);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule